// File: doc/BRIEF.md
# SPI Frame CRC-8 Checker and Generator

This block guards the command and response bytes of a chip-select framed serial link with an 8-bit CRC. On the receive side it watches the byte stream taken from the serial input. It skips a configurable number of leading pad bytes and folds the next two command bytes into a CRC register. It then compares the result with the check byte that the host sends after them. When chip-select is released, a matching frame, or any complete frame while checking is off, produces a one-cycle execute strobe along with the captured command word. A frame whose check byte is wrong is dropped, and the active-low fault flag goes low.

On the transmit side the block supplies each byte of the response in turn as the serial layer asks for it. The response can start with an optional two-byte status header, which carries the fault flag from the previous frame. Three data bytes follow: either conversion data, or a register byte, its address and a zero pad. The block keeps a CRC over these bytes and sends it right after the last one. The shift register, the register file and the data source are outside the block; plain byte strobes stand in for them.

Top module: `spi_crc8_unit`

## Requirements
- R1: The CRC uses the generator x^8+x^2+x+1 (0x07). It starts from 0xFF in every frame and processes each byte most significant bit first, with no bit reflection and no final inversion.
- R2: The receive CRC covers only the two command bytes. A frame carries PAD_BYTES pad bytes, then the command high byte, the command low byte and the check byte, in that order. Pad bytes and any bytes after the check byte do not affect the result.
- R3: With crc_en=1, a complete frame whose check byte differs from the computed CRC raises no exec_stb, and fault_n reads 0 from the cycle after cs_n rises.
- R4: A complete frame that passes the check, or any complete frame while crc_en=0, gives exec_stb high for exactly one cycle, in the cycle after cs_n rises. While exec_stb is high, cmd_word equals {high byte, low byte}.
- R5: A frame is complete when it holds PAD_BYTES+3 received bytes (PAD_BYTES+2 when crc_en=0). An incomplete frame is never executed and leaves fault_n at 1.
- R6: fault_n is 1 after reset and changes only in the cycle after a frame ends. After any frame without a CRC error it returns to 1.
- R7: With hdr_en=0 the response is three data bytes. For a conversion read (rd_reg=0) they are conv_data[23:16], conv_data[15:8] and conv_data[7:0]. For a register read (rd_reg=1) they are reg_data, reg_addr and 0x00. The CRC byte covers exactly these three bytes.
- R8: With hdr_en=1 the response starts with status_in[15:8], then {status_in[7:1], fault_n}, followed by the three data bytes of R7. The CRC byte covers all five bytes.
- R9: The CRC byte follows the last covered byte when crc_en=1; when crc_en=0, a 0x00 byte takes its place. Every byte after that position is 0x00.
- R10: While cs_n is high, both CRC registers hold 0xFF and the byte positions return to the start of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Frame select, active low |
| crc_en | input | 1 | Enables CRC checking and the CRC byte in the response |
| hdr_en | input | 1 | Enables the two-byte status header in the response |
| rd_reg | input | 1 | 1 = register read response, 0 = conversion data response |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_next | input | 1 | Current tx_byte has been taken; advance to the next byte |
| status_in | input | 16 | Status header content; bit 0 is replaced by fault_n |
| conv_data | input | 24 | Conversion result |
| reg_data | input | 8 | Register contents for a register read |
| reg_addr | input | 8 | Register address for a register read |
| tx_byte | output | 8 | Byte to send at the current response position |
| exec_stb | output | 1 | One-cycle command execute strobe |
| cmd_word | output | 16 | Captured command word |
| fault_n | output | 1 | CRC fault flag, active low |

## Verification
The bench builds the block with PAD_BYTES=2. This puts more than one excluded pad byte ahead of the command, so a pad-skip counter that is off by one or miscounts would feed a pad byte into the CRC and fail the check. CMD_BYTES, DATA_BYTES and the generator keep their defaults. With those defaults the five-byte header response and the three-byte response both occur, for conversion reads and for register reads. The random frames also cover short frames and frames with extra bytes after the check byte.

// File: rtl/spicrc_pkg.sv
package spicrc_pkg;

  localparam int BYTE_W = 8;

  // One byte folded into the CRC, most significant bit first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int b = BYTE_W - 1; b >= 0; b--) begin
      fb = c[7] ^ din[b];
      c  = {c[6:0], 1'b0} ^ (fb ? poly : 8'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/crc8_accum.sv
module crc8_accum #(
  parameter logic [7:0] POLY   = 8'h07,
  parameter logic [7:0] PRESET = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import spicrc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= PRESET;
    else if (clear)  crc <= PRESET;
    else if (en)     crc <= crc8_step(crc, din, POLY);
  end
endmodule

// File: rtl/cmd_checker.sv
module cmd_checker #(
  parameter int         PAD_BYTES = 1,
  parameter int         CMD_BYTES = 2,
  parameter logic [7:0] POLY      = 8'h07,
  parameter logic [7:0] PRESET    = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   frame_end,
  input  logic                   crc_en,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  output logic                   exec_stb,
  output logic [CMD_BYTES*8-1:0] cmd_word,
  output logic                   fault_n,
  output logic [7:0]             crc_calc
);
  localparam int LAST  = PAD_BYTES + CMD_BYTES;
  localparam int CNT_W = $clog2(LAST + 2);
  localparam int CW    = CMD_BYTES * 8;

  logic [CNT_W-1:0] rx_cnt;
  logic [7:0]       crc_rx;
  logic             in_cmd, is_chk, complete, mismatch;

  assign in_cmd   = rx_valid && !cs_n && (rx_cnt >= CNT_W'(PAD_BYTES)) && (rx_cnt < CNT_W'(LAST));
  assign is_chk   = rx_valid && !cs_n && (rx_cnt == CNT_W'(LAST));
  assign complete = crc_en ? (rx_cnt > CNT_W'(LAST)) : (rx_cnt >= CNT_W'(LAST));
  assign mismatch = (crc_rx != crc_calc);

  crc8_accum #(.POLY(POLY), .PRESET(PRESET)) u_rx_crc (
    .clk(clk), .rst_n(rst_n), .clear(cs_n), .en(in_cmd), .din(rx_byte), .crc(crc_calc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt   <= '0;
      crc_rx   <= '0;
      cmd_word <= '0;
    end else if (cs_n) begin
      rx_cnt <= '0;
    end else if (rx_valid) begin
      if (rx_cnt <= CNT_W'(LAST)) rx_cnt <= rx_cnt + 1'b1;
      if (in_cmd) cmd_word <= {cmd_word[CW-9:0], rx_byte};
      if (is_chk) crc_rx   <= rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_stb <= 1'b0;
      fault_n  <= 1'b1;
    end else if (frame_end) begin
      exec_stb <= complete && (!crc_en || !mismatch);
      fault_n  <= !(crc_en && complete && mismatch);
    end else begin
      exec_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_framer.sv
module resp_framer #(
  parameter int         DATA_BYTES = 3,
  parameter logic [7:0] POLY       = 8'h07,
  parameter logic [7:0] PRESET     = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    crc_en,
  input  logic                    hdr_en,
  input  logic                    rd_reg,
  input  logic                    tx_next,
  input  logic                    fault_n,
  input  logic [15:0]             status_in,
  input  logic [DATA_BYTES*8-1:0] conv_data,
  input  logic [7:0]              reg_data,
  input  logic [7:0]              reg_addr,
  output logic [7:0]              tx_byte,
  output logic [7:0]              tx_crc
);
  localparam int HDR_BYTES = 2;
  localparam int TOT       = HDR_BYTES + DATA_BYTES;
  localparam int IDX_W     = $clog2(TOT + 2);

  logic [IDX_W-1:0]        tx_idx;
  logic [IDX_W-1:0]        covered;
  logic [DATA_BYTES*8-1:0] data_v;
  logic [TOT*8-1:0]        full_v;
  logic                    take_crc;

  assign covered  = hdr_en ? IDX_W'(TOT) : IDX_W'(DATA_BYTES);
  assign data_v   = rd_reg ? {reg_data, reg_addr, {(DATA_BYTES-2)*8{1'b0}}} : conv_data;
  assign full_v   = {status_in[15:1], fault_n, data_v};
  assign take_crc = tx_next && !cs_n && (tx_idx < covered);

  always_comb begin
    int pos;
    pos     = hdr_en ? int'(tx_idx) : int'(tx_idx) + HDR_BYTES;
    tx_byte = 8'h00;
    if (tx_idx < covered)                tx_byte = full_v[(TOT-1-pos)*8 +: 8];
    else if (tx_idx == covered && crc_en) tx_byte = tx_crc;
  end

  crc8_accum #(.POLY(POLY), .PRESET(PRESET)) u_tx_crc (
    .clk(clk), .rst_n(rst_n), .clear(cs_n), .en(take_crc), .din(tx_byte), .crc(tx_crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              tx_idx <= '0;
    else if (cs_n)                           tx_idx <= '0;
    else if (tx_next && tx_idx <= covered)   tx_idx <= tx_idx + 1'b1;
  end
endmodule

// File: rtl/spi_crc8_unit.sv
module spi_crc8_unit #(
  parameter int         PAD_BYTES  = 1,
  parameter int         CMD_BYTES  = 2,
  parameter int         DATA_BYTES = 3,
  parameter logic [7:0] POLY       = 8'h07,
  parameter logic [7:0] PRESET     = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    crc_en,
  input  logic                    hdr_en,
  input  logic                    rd_reg,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic                    tx_next,
  input  logic [15:0]             status_in,
  input  logic [DATA_BYTES*8-1:0] conv_data,
  input  logic [7:0]              reg_data,
  input  logic [7:0]              reg_addr,
  output logic [7:0]              tx_byte,
  output logic                    exec_stb,
  output logic [CMD_BYTES*8-1:0]  cmd_word,
  output logic                    fault_n
);
  logic       cs_q;
  logic       frame_end;
  logic [7:0] rx_crc;
  logic [7:0] tx_crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign frame_end = !cs_q && cs_n;

  cmd_checker #(.PAD_BYTES(PAD_BYTES), .CMD_BYTES(CMD_BYTES), .POLY(POLY), .PRESET(PRESET)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frame_end(frame_end), .crc_en(crc_en),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .exec_stb(exec_stb), .cmd_word(cmd_word),
    .fault_n(fault_n), .crc_calc(rx_crc)
  );

  resp_framer #(.DATA_BYTES(DATA_BYTES), .POLY(POLY), .PRESET(PRESET)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .crc_en(crc_en), .hdr_en(hdr_en), .rd_reg(rd_reg),
    .tx_next(tx_next), .fault_n(fault_n), .status_in(status_in), .conv_data(conv_data),
    .reg_data(reg_data), .reg_addr(reg_addr), .tx_byte(tx_byte), .tx_crc(tx_crc)
  );
endmodule

// File: rtl/spi_crc8_unit_chk.sv
module spi_crc8_unit_chk #(
  parameter logic [7:0] PRESET = 8'hFF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       frame_end,
  input logic       exec_stb,
  input logic       fault_n,
  input logic [7:0] rx_crc,
  input logic [7:0] tx_crc
);
  AST_EXEC_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> $past(frame_end)); // R4
  AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> !exec_stb); // R4
  AST_EXEC_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> fault_n); // R3
  AST_FAULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_n) |-> $past(frame_end)); // R6
  AST_RX_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> rx_crc == PRESET); // R10
  AST_TX_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> tx_crc == PRESET); // R10
endmodule

bind spi_crc8_unit spi_crc8_unit_chk #(.PRESET(PRESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frame_end(frame_end), .exec_stb(exec_stb),
  .fault_n(fault_n), .rx_crc(rx_crc), .tx_crc(tx_crc)
);

// File: tb/tb_spi_crc8_unit.sv
module tb_spi_crc8_unit;
  localparam int PAD = 2;

  logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic        crc_en = 1'b1, hdr_en = 1'b1, rd_reg = 1'b0;
  logic        rx_valid = 1'b0, tx_next = 1'b0;
  logic [7:0]  rx_byte = 8'h00, reg_data = 8'h00, reg_addr = 8'h00, tx_byte;
  logic [15:0] status_in = 16'h0000, cmd_word;
  logic [23:0] conv_data = 24'h000000;
  logic        exec_stb, fault_n;

  int checks = 0, errors = 0;
  bit fault_m = 1'b1;

  always #10 clk = ~clk;

  spi_crc8_unit #(.PAD_BYTES(PAD)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .crc_en(crc_en), .hdr_en(hdr_en), .rd_reg(rd_reg),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_next(tx_next), .status_in(status_in),
    .conv_data(conv_data), .reg_data(reg_data), .reg_addr(reg_addr), .tx_byte(tx_byte),
    .exec_stb(exec_stb), .cmd_word(cmd_word), .fault_n(fault_n)
  );

  // Bench model: XOR the byte into the top, then eight conditional shifts.
  function automatic bit [7:0] m_crc(input bit [7:0] c, input bit [7:0] d);
    c = c ^ d;
    repeat (8) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic frame(input bit [15:0] cmd, input bit corrupt, input int nrx, input int ntx);
    bit [7:0] exp_tx [0:7];
    bit [7:0] good, c;
    int       n, need;
    bit       complete, exp_exec;
    good = m_crc(m_crc(8'hFF, cmd[15:8]), cmd[7:0]);
    for (int k = 0; k < 8; k++) exp_tx[k] = 8'h00;
    n = 0;
    if (hdr_en) begin
      exp_tx[0] = status_in[15:8];
      exp_tx[1] = {status_in[7:1], fault_m};
      n = 2;
    end
    if (rd_reg) begin
      exp_tx[n] = reg_data; exp_tx[n+1] = reg_addr; exp_tx[n+2] = 8'h00;
    end else begin
      exp_tx[n] = conv_data[23:16]; exp_tx[n+1] = conv_data[15:8]; exp_tx[n+2] = conv_data[7:0];
    end
    n = n + 3;
    c = 8'hFF;
    for (int k = 0; k < n; k++) c = m_crc(c, exp_tx[k]);
    exp_tx[n] = crc_en ? c : 8'h00;

    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nrx; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      if (i < PAD)          rx_byte = 8'($urandom);
      else if (i == PAD)    rx_byte = cmd[15:8];
      else if (i == PAD+1)  rx_byte = cmd[7:0];
      else if (i == PAD+2)  rx_byte = corrupt ? (good ^ 8'(1 + $urandom_range(0, 254))) : good;
      else                  rx_byte = 8'($urandom);
    end
    @(negedge clk) rx_valid = 1'b0;
    for (int j = 0; j < ntx; j++) begin
      @(negedge clk);
      if (j < n)       chk(hdr_en ? "R8" : "R7", "tx data byte", tx_byte, exp_tx[j]);
      else if (j == n) chk(crc_en ? "R1" : "R9", "tx crc byte", tx_byte, exp_tx[j]);
      else             chk("R9", "tx tail byte", tx_byte, 8'h00);
      tx_next = 1'b1;
    end
    @(negedge clk) tx_next = 1'b0;
    cs_n = 1'b1;

    need     = PAD + 2 + (crc_en ? 1 : 0);
    complete = (nrx >= need);
    exp_exec = complete && (!crc_en || !corrupt);
    @(negedge clk);
    chk(exp_exec ? "R4" : (complete ? "R3" : "R5"), "exec_stb", exec_stb, exp_exec);
    if (exp_exec) chk("R2", "cmd_word", cmd_word, cmd);
    fault_m = !(crc_en && complete && corrupt);
    chk("R6", "fault_n", fault_n, fault_m);
    @(negedge clk);
    chk("R4", "exec_stb width", exec_stb, 1'b0);
  endtask

  task automatic randomize_cfg();
    crc_en    = ($urandom_range(0, 3) != 0);
    hdr_en    = $urandom_range(0, 1);
    rd_reg    = $urandom_range(0, 1);
    status_in = 16'($urandom);
    conv_data = 24'($urandom);
    reg_data  = 8'($urandom);
    reg_addr  = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    chk("R6", "fault_n after reset", fault_n, 1'b1);
    chk("R4", "exec_stb after reset", exec_stb, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    status_in = 16'hA5C3; conv_data = 24'h123456; reg_data = 8'h9E; reg_addr = 8'h41;
    crc_en = 1; hdr_en = 1; rd_reg = 0;
    frame(16'h4102, 1'b0, PAD + 3, 8);   // clean frame, header response
    frame(16'h2233, 1'b1, PAD + 3, 8);   // R3 wrong check byte
    frame(16'h7001, 1'b0, PAD + 3, 8);   // R8 header shows fault, R6 clears
    crc_en = 0;
    frame(16'h0F0F, 1'b1, PAD + 3, 6);   // R9 checking off executes anyway
    crc_en = 1;
    frame(16'hBEEF, 1'b0, PAD + 2, 6);   // R5 short frame
    frame(16'hFFFF, 1'b0, PAD + 6, 6);   // R2 trailing bytes ignored
    hdr_en = 0; rd_reg = 1;
    frame(16'h0000, 1'b0, PAD + 3, 6);   // R7 register read, no header

    for (int f = 0; f < 80; f++) begin
      int nrx;
      randomize_cfg();
      nrx = ($urandom_range(0, 6) == 0) ? $urandom_range(0, PAD + 2) : PAD + 3 + $urandom_range(0, 2);
      frame(16'($urandom), ($urandom_range(0, 2) == 0), nrx, (hdr_en ? 5 : 3) + 1 + $urandom_range(0, 2));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule